// File: doc/BRIEF.md
# Condition Code Flag Micro-Op Unit

This block holds the six status flags of an 8-bit processor datapath (half-carry, interrupt mask, negative, zero, overflow and carry) and updates them under control of byte-wide micro-operations from a microsequencer. A flag micro-op names a single flag and one of three actions: force it to 0, force it to 1, or copy the matching flag output of the ALU into it. A fourth action value marks a reserved group. Those codes never touch the flags; the block instead raises a one-cycle marker carrying the code's low three bits.

A separate strobe writes all six flags at once from the internal bus. Microcode uses it to restore the flags from memory. It wins over any flag micro-op presented in the same cycle. The flag register drives the output port directly, so a change made at a clock edge is visible right after that edge.

Top module: `ccr_flag_unit`

## Requirements
- R1: While reset is asserted and right after it, `ccrOut` equals 6'b010000 (only the interrupt mask set) and `specialPulse` is 0.
- R2: Bit layout of `ccrOut`: bit 5 = H, bit 4 = I, bit 3 = N, bit 2 = Z, bit 1 = V, bit 0 = C. An accepted code of the form 110_00_iii (iii = 0 to 5 picking H, I, N, Z, V, C in that order, so codes 192 to 197) clears the chosen flag at the next edge.
- R3: Codes 110_01_iii (200 to 205) set the chosen flag to 1 at the next edge.
- R4: Codes 110_10_iii (208 to 213) copy the chosen ALU flag input into the flag. Code 209 (interrupt mask) has no ALU source and leaves the register unchanged.
- R5: A flag micro-op changes at most the one addressed bit. All other bits keep their values.
- R6: Clear, set and copy codes whose index field is 110 or 111 leave the register unchanged.
- R7: Codes 110_11_xxx (216 to 223) leave the register unchanged. In the following cycle `specialPulse` is 1 for exactly one cycle and `specialCode` equals xxx.
- R8: A code is ignored when `opValid` is 0 or when its top three bits are not 110.
- R9: When `busLoad` is 1, `ccrOut` takes `busData` at the next edge, whatever flag micro-op is present. A reserved code in the same cycle still produces its pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous reset, active low |
| opCode | input | 8 | Micro-op byte |
| opValid | input | 1 | Qualifies `opCode` this cycle |
| aluH | input | 1 | ALU half-carry result |
| aluN | input | 1 | ALU negative result |
| aluZ | input | 1 | ALU zero result |
| aluV | input | 1 | ALU overflow result |
| aluC | input | 1 | ALU carry result |
| busLoad | input | 1 | Parallel write of all flags |
| busData | input | 6 | Flag values for a parallel write, R2 layout |
| ccrOut | output | 6 | Current flag register |
| specialPulse | output | 1 | One-cycle marker for a reserved code |
| specialCode | output | 3 | Low bits of the reserved code |

## Verification
The flag register drives `ccrOut` with no logic in between. A wrong index decode, a leaked write-enable or a lost priority therefore shows on the port one edge after the offending micro-op. The bench compares `ccrOut` after every step, and each step starts from a known value. A stray bit flip is therefore traced to the step that caused it. A mis-decoded reserved code shows either as a register change or as a missing or wrong pulse one cycle later.

// File: rtl/ccr_pkg.sv
package ccr_pkg;
  localparam int CCR_W = 6;
  localparam int OP_W  = 8;
  localparam int IDX_W = 3;

  localparam logic [2:0] FLAG_GROUP = 3'b110;
  localparam logic [CCR_W-1:0] CCR_RESET = 6'b010000;
  // bit that has no ALU source (interrupt mask)
  localparam logic [CCR_W-1:0] ALU_SOURCED = 6'b101111;

  typedef enum logic [1:0] {
    ACT_CLEAR = 2'b00,
    ACT_SET   = 2'b01,
    ACT_COPY  = 2'b10,
    ACT_SPEC  = 2'b11
  } flagAct_e;

  typedef struct packed {
    logic             loadAll;
    logic [CCR_W-1:0] setMask;
    logic [CCR_W-1:0] clrMask;
    logic [CCR_W-1:0] copyMask;
  } ccrStrobe_t;
endpackage

// File: rtl/ccr_ctrl.sv
module ccr_ctrl
  import ccr_pkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  logic [OP_W-1:0] opCode,
  input  logic            opValid,
  input  logic            busLoad,
  output ccrStrobe_t      strobe,
  output logic            specialPulse,
  output logic [IDX_W-1:0] specialCode
);
  logic             inGroup;
  flagAct_e         act;
  logic [IDX_W-1:0] idx;
  logic [CCR_W-1:0] bitSel;

  assign inGroup = opValid && (opCode[OP_W-1 -: 3] == FLAG_GROUP);
  assign act     = flagAct_e'(opCode[4:3]);
  assign idx     = opCode[IDX_W-1:0];

  // index 0 addresses the top bit; indices past the last flag select nothing
  always_comb begin
    bitSel = '0;
    for (int b = 0; b < CCR_W; b++) begin
      if (int'(idx) == CCR_W - 1 - b) bitSel[b] = 1'b1;
    end
  end

  always_comb begin
    strobe          = '0;
    strobe.loadAll  = busLoad;
    if (inGroup) begin
      unique case (act)
        ACT_CLEAR: strobe.clrMask  = bitSel;
        ACT_SET:   strobe.setMask  = bitSel;
        ACT_COPY:  strobe.copyMask = bitSel & ALU_SOURCED;
        default:   ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      specialPulse <= 1'b0;
      specialCode  <= '0;
    end else begin
      specialPulse <= inGroup && (act == ACT_SPEC);
      specialCode  <= (inGroup && act == ACT_SPEC) ? idx : '0;
    end
  end

  assert_special_pulse_R7: assert property (@(posedge clk) disable iff (!rstN)
    (inGroup && act == ACT_SPEC) |=> (specialPulse && specialCode == $past(opCode[IDX_W-1:0])));

  assert_special_only_R7: assert property (@(posedge clk) disable iff (!rstN)
    !(inGroup && act == ACT_SPEC) |=> !specialPulse);
endmodule

// File: rtl/ccr_dp.sv
module ccr_dp
  import ccr_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  ccrStrobe_t       strobe,
  input  logic [CCR_W-1:0] busBits,
  input  logic [CCR_W-1:0] aluVec,
  output logic [CCR_W-1:0] ccrQ
);
  for (genvar b = 0; b < CCR_W; b++) begin : g_flag
    always_ff @(posedge clk) begin
      if (!rstN)                   ccrQ[b] <= CCR_RESET[b];
      else if (strobe.loadAll)     ccrQ[b] <= busBits[b];
      else if (strobe.setMask[b])  ccrQ[b] <= 1'b1;
      else if (strobe.clrMask[b])  ccrQ[b] <= 1'b0;
      else if (strobe.copyMask[b]) ccrQ[b] <= aluVec[b];
    end
  end

  assert_busload_R9: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadAll |=> ccrQ == $past(busBits));

  assert_one_bit_R5: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.loadAll |=> $countones(ccrQ ^ $past(ccrQ)) <= 1);

  assert_set_R3: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.loadAll && |strobe.setMask) |=> ((ccrQ & $past(strobe.setMask)) == $past(strobe.setMask)));

  assert_clear_R2: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.loadAll && |strobe.clrMask) |=> ((ccrQ & $past(strobe.clrMask)) == '0));
endmodule

// File: rtl/ccr_flag_unit.sv
module ccr_flag_unit
  import ccr_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic [OP_W-1:0]  opCode,
  input  logic             opValid,
  input  logic             aluH,
  input  logic             aluN,
  input  logic             aluZ,
  input  logic             aluV,
  input  logic             aluC,
  input  logic             busLoad,
  input  logic [CCR_W-1:0] busData,
  output logic [CCR_W-1:0] ccrOut,
  output logic             specialPulse,
  output logic [IDX_W-1:0] specialCode
);
  ccrStrobe_t       strobe;
  logic [CCR_W-1:0] aluVec;

  assign aluVec = {aluH, 1'b0, aluN, aluZ, aluV, aluC};

  ccr_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .opCode(opCode), .opValid(opValid),
    .busLoad(busLoad), .strobe(strobe),
    .specialPulse(specialPulse), .specialCode(specialCode)
  );

  ccr_dp u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .busBits(busData),
    .aluVec(aluVec), .ccrQ(ccrOut)
  );

  assert_idle_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    (!opValid && !busLoad) |=> $stable(ccrOut));

  assert_reset_value_R1: assert property (@(posedge clk)
    !rstN |=> (ccrOut == CCR_RESET && !specialPulse));
endmodule

// File: tb/ccr_flag_unit_tb.sv
module ccr_flag_unit_tb;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] opCode = '0;
  logic       opValid = 1'b0;
  logic [4:0] alu = '0;  // {H,N,Z,V,C}
  logic       busLoad = 1'b0;
  logic [5:0] busData = '0;
  logic [5:0] ccrOut;
  logic       specialPulse;
  logic [2:0] specialCode;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  ccr_flag_unit u_dut (
    .clk(clk), .rstN(rstN), .opCode(opCode), .opValid(opValid),
    .aluH(alu[4]), .aluN(alu[3]), .aluZ(alu[2]), .aluV(alu[1]), .aluC(alu[0]),
    .busLoad(busLoad), .busData(busData),
    .ccrOut(ccrOut), .specialPulse(specialPulse), .specialCode(specialCode)
  );

  task automatic check(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, got, exp);
    end
  endtask

  // one cycle of stimulus; results are sampled at the next falling edge
  task automatic step(input logic [7:0] op, input logic v, input logic bl,
                      input logic [5:0] bd, input logic [4:0] a);
    opCode = op; opValid = v; busLoad = bl; busData = bd; alu = a;
    @(negedge clk);
    opCode = '0; opValid = 1'b0; busLoad = 1'b0; busData = '0;
  endtask

  function automatic int bitOf(input int idx);
    return 5 - idx;
  endfunction

  task automatic testReset();
    check("R1 reset ccr", ccrOut, 6'b010000);
    check("R1 reset pulse", specialPulse, 0);
  endtask

  task automatic testClear();
    for (int i = 0; i < 6; i++) begin
      step(8'h00, 1'b0, 1'b1, 6'h3F, '0);
      step(8'(192 + i), 1'b1, 1'b0, '0, '0);
      check("R2 clear", ccrOut, 6'h3F & ~(6'h01 << bitOf(i)));
      check("R5 clear others", ccrOut | (6'h01 << bitOf(i)), 6'h3F);
    end
  endtask

  task automatic testSet();
    for (int i = 0; i < 6; i++) begin
      step(8'h00, 1'b0, 1'b1, 6'h00, '0);
      step(8'(200 + i), 1'b1, 1'b0, '0, '0);
      check("R3 set", ccrOut, 6'h01 << bitOf(i));
    end
  endtask

  task automatic testCopy();
    logic [5:0] exp;
    // H,N,Z,V,C with ALU value 1 and then 0
    for (int pass = 0; pass < 2; pass++) begin
      for (int i = 0; i < 6; i++) begin
        if (i == 1) continue;
        exp = (pass == 0) ? 6'h00 : 6'h3F;
        step(8'h00, 1'b0, 1'b1, exp, '0);
        step(8'(208 + i), 1'b1, 1'b0, '0, (pass == 0) ? 5'h1F : 5'h00);
        if (pass == 0) exp[bitOf(i)] = 1'b1; else exp[bitOf(i)] = 1'b0;
        check("R4 copy", ccrOut, exp);
      end
    end
    step(8'h00, 1'b0, 1'b1, 6'b101010, '0);
    step(8'd209, 1'b1, 1'b0, '0, 5'h1F);
    check("R4 copy I no source", ccrOut, 6'b101010);
    step(8'h00, 1'b0, 1'b1, 6'b111111, '0);
    step(8'd209, 1'b1, 1'b0, '0, 5'h00);
    check("R4 copy I no source", ccrOut, 6'b111111);
  endtask

  task automatic testBadIndex();
    logic [7:0] codes [6] = '{8'd198, 8'd199, 8'd206, 8'd207, 8'd214, 8'd215};
    for (int k = 0; k < 6; k++) begin
      step(8'h00, 1'b0, 1'b1, 6'b011001, '0);
      step(codes[k], 1'b1, 1'b0, '0, 5'h1F);
      check("R6 bad index", ccrOut, 6'b011001);
      step(8'h00, 1'b0, 1'b1, 6'b100110, '0);
      step(codes[k], 1'b1, 1'b0, '0, 5'h00);
      check("R6 bad index", ccrOut, 6'b100110);
    end
  endtask

  task automatic testSpecial();
    for (int i = 0; i < 8; i++) begin
      step(8'h00, 1'b0, 1'b1, 6'b110100, '0);
      step(8'(216 + i), 1'b1, 1'b0, '0, 5'h1F);
      check("R7 special ccr", ccrOut, 6'b110100);
      check("R7 special pulse", specialPulse, 1);
      check("R7 special code", specialCode, i);
      @(negedge clk);
      check("R7 pulse ends", specialPulse, 0);
    end
  endtask

  task automatic testIgnored();
    step(8'h00, 1'b0, 1'b1, 6'h00, '0);
    step(8'd200, 1'b0, 1'b0, '0, '0);
    check("R8 invalid ignored", ccrOut, 6'h00);
    step(8'd219, 1'b0, 1'b0, '0, '0);
    check("R8 invalid special", specialPulse, 0);
    step(8'h48, 1'b1, 1'b0, '0, 5'h1F);   // 010_01_000 outside group
    check("R8 other group", ccrOut, 6'h00);
    step(8'hE8, 1'b1, 1'b0, '0, 5'h1F);   // 111_01_000
    check("R8 other group", ccrOut, 6'h00);
    check("R8 other group pulse", specialPulse, 0);
  endtask

  task automatic testPriority();
    step(8'h00, 1'b0, 1'b1, 6'h00, '0);
    step(8'd200, 1'b1, 1'b1, 6'b000101, '0);
    check("R9 bus over set", ccrOut, 6'b000101);
    step(8'd197, 1'b1, 1'b1, 6'b000001, '0);
    check("R9 bus over clear", ccrOut, 6'b000001);
    step(8'd222, 1'b1, 1'b1, 6'b111110, '0);
    check("R9 bus with special", ccrOut, 6'b111110);
    check("R9 special pulse kept", specialPulse, 1);
    check("R9 special code kept", specialCode, 6);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testClear();
    testSet();
    testCopy();
    testBadIndex();
    testSpecial();
    testIgnored();
    testPriority();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule